// File: doc/BRIEF.md
# Phase Error Median Clock Corrector

This block keeps a node's slot timer aligned with its neighbours in a time-slotted radio network. Each time a neighbour's message ends, the block is told which transmit slot that neighbour owns. On the next tick it compares the local slot and tick position against the instant the message was due to end, and stores the difference as a signed phase error in ticks. Up to a fixed number of errors are kept per frame.

Once per frame, at a fixed slot in the sleeping part of the frame, the block picks a median of the stored errors and halves it. It then issues a one-cycle load of a corrected slot and tick value to the slot timer and clears its error store for the next frame. The halving truncates toward zero, so an error of one tick in either direction produces no correction. If no message arrived in the frame, no load is issued and the reported offset is zero.

Top module: `phase_median_corrector`

## Requirements
- R1: After reset `load_en` is 0 and `corr_offset` is 0.
- R2: A message end is stored as a phase error on the first cycle with `tick_en` high after the cycle with `msg_end` high. The error is (msg_slot*K + K - G) - (cur_slot*K + cur_tick), using `cur_slot` and `cur_tick` from that tick cycle. No error is stored without `tick_en`.
- R3: At most DEPTH (default 8) errors are kept per frame. Message ends beyond that count in the same frame are ignored.
- R4: With one or two stored errors, the median is the first stored error. With three or more, the median is the element at ascending sorted index (count-1)/2, which is the lower middle value for an even count.
- R5: The offset is the median divided by 2, truncated toward zero. A median of 1 or -1 gives 0, and -3 gives -1.
- R6: The decision tick is the first `tick_en` cycle with `cur_slot` == (C+N_ACT)/2 since reset or since the last `tick_en` cycle with `cur_slot` == 0. The results appear on the cycle after that tick. `load_en` is a single-cycle pulse, and further ticks in the same frame cause no second decision.
- R7: A decision with no stored errors raises no `load_en` and sets `corr_offset` to 0.
- R8: With P = cur_slot*K + offset, wrapped into [0, C*K), a load carries `load_slot` = P / K and `load_tick` = P % K. The decision tick's `cur_tick` is discarded.
- R9: Every decision empties the error store, so the next frame's median uses only that frame's messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe for each timer tick |
| msg_end | input | 1 | Strobe marking the end of a received message |
| msg_slot | input | SLOT_W | Transmit slot of the sender of that message |
| cur_slot | input | SLOT_W | Local slot counter |
| cur_tick | input | TICK_W | Local tick-within-slot counter |
| load_en | output | 1 | Pulse to load the corrected position into the timer |
| load_slot | output | SLOT_W | Corrected slot |
| load_tick | output | TICK_W | Corrected tick |
| corr_offset | output | OFS_W | Signed correction of the last decision |

## Verification
The hardest situation to reach from the ports is a median decided by sorting over a full or overflowing error store. To get there, a frame must deliver many message ends, each followed by a tick, with the errors spread so that the insertion order differs from the sorted order. The bench drives the timer position itself. For each count from 0 to 10 it sends pattern-generated senders and local positions, then compares the result against a sorted model. It also sweeps every pairing of sender slot and local slot with a single message, which covers positive wrap-around, and it drives small errors to show that the halving truncates them.

// File: rtl/pmc_pkg.sv
// Package: arithmetic helpers shared by the phase error corrector.
// Assumes all operands fit comfortably in 32-bit signed integers.
package pmc_pkg;

    // Ticks between the expected end of the sender's window and the local position.
    function automatic int phase_error(int snd_slot, int loc_slot, int loc_tick,
                                       int ticks_per_slot, int guard);
        return (snd_slot * ticks_per_slot + ticks_per_slot - guard)
             - (loc_slot * ticks_per_slot + loc_tick);
    endfunction

    // Gain of one half, rounding toward zero for both signs.
    function automatic int halve_tz(int v);
        if (v < 0) return -((-v) / 2);
        return v / 2;
    endfunction

endpackage

// File: rtl/pmc_err_store.sv
// Module: captures message-end events and stores one phase error per event on
// the next tick. Assumes at most one pending event; a later event before a tick
// replaces it. Holds up to DEPTH errors until clear is raised.
module pmc_err_store
    import pmc_pkg::*;
#(
    parameter int K      = 29,
    parameter int G      = 9,
    parameter int DEPTH  = 8,
    parameter int SLOT_W = 4,
    parameter int TICK_W = 5,
    parameter int EW     = 11,
    parameter int CW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 msg_end,
    input  logic [SLOT_W-1:0]    msg_slot,
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic [TICK_W-1:0]    cur_tick,
    input  logic                 clear,
    output logic signed [EW-1:0] errs [DEPTH],
    output logic [CW-1:0]        cnt
);

    logic              pend;
    logic [SLOT_W-1:0] pend_slot;
    logic              store;
    logic              wr_en;
    logic [CW-1:0]     wr_idx;
    logic signed [EW-1:0] new_err;

    assign store   = tick_en && pend;
    assign wr_idx  = clear ? '0 : cnt;
    assign wr_en   = store && (clear || (cnt < CW'(DEPTH)));
    assign new_err = EW'(phase_error(int'(pend_slot), int'(cur_slot), int'(cur_tick), K, G));

    // Holds the latest message-end event until a tick consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_slot <= '0;
        end else if (msg_end) begin
            pend      <= 1'b1;
            pend_slot <= msg_slot;
        end else if (tick_en) begin
            pend      <= 1'b0;
        end
    end

    // Counts stored errors; a clear restarts the frame at zero or one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= store ? CW'(1) : '0;
        end else if (wr_en) begin
            cnt <= cnt + CW'(1);
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        // Writes one buffer entry when it is the next free slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                errs[gi] <= '0;
            end else if (wr_en && (wr_idx == CW'(gi))) begin
                errs[gi] <= new_err;
            end
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R3
    AST_STORE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> $past(tick_en)); // R2
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !store) |=> (cnt == '0)); // R9

endmodule

// File: rtl/pmc_median.sv
// Module: combinational median selector. Entries at index >= cnt are ignored.
// With cnt <= 2 the first entry is chosen, otherwise the lower middle of the
// ascending order, found by ranking each entry (ties broken by index).
module pmc_median #(
    parameter int DEPTH = 8,
    parameter int EW    = 11,
    parameter int CW    = 4
) (
    input  logic signed [EW-1:0] errs [DEPTH],
    input  logic [CW-1:0]        cnt,
    output logic signed [EW-1:0] med
);

    logic [CW-1:0] rank [DEPTH];
    logic [CW-1:0] target;

    // Ranks every valid entry by how many valid entries sort before it.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if ((CW'(j) < cnt) && (j != i) &&
                    ((errs[j] < errs[i]) || ((errs[j] == errs[i]) && (j < i)))) begin
                    rank[i] = rank[i] + CW'(1);
                end
            end
        end
    end

    // Picks the entry whose rank matches the lower-middle position.
    always_comb begin
        target = (cnt - CW'(1)) >> 1;
        med    = errs[0];
        if (cnt > CW'(2)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((CW'(i) < cnt) && (rank[i] == target)) begin
                    med = errs[i];
                end
            end
        end
    end

endmodule

// File: rtl/pmc_apply.sv
// Module: decides once per frame, at slot (C+N_ACT)/2, whether to correct the
// timer. Halves the median, forms the wrapped corrected position and registers
// the load strobe and values. Assumes the timer passes slot 0 every frame.
module pmc_apply
    import pmc_pkg::*;
#(
    parameter int C      = 10,
    parameter int N_ACT  = 3,
    parameter int K      = 29,
    parameter int SLOT_W = 4,
    parameter int TICK_W = 5,
    parameter int EW     = 11,
    parameter int CW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic [CW-1:0]        cnt,
    input  logic signed [EW-1:0] med,
    output logic                 decide,
    output logic                 load_en,
    output logic [SLOT_W-1:0]    load_slot,
    output logic [TICK_W-1:0]    load_tick,
    output logic signed [EW-1:0] corr_offset
);

    localparam int SYNC_SLOT   = (C + N_ACT) / 2;
    localparam int FRAME_TICKS = C * K;

    logic armed;
    int   ofs_c;
    int   pos;

    assign decide = tick_en && armed && (cur_slot == SLOT_W'(SYNC_SLOT));

    // Arms at frame start and disarms after the one decision of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (tick_en && (cur_slot == '0)) begin
            armed <= 1'b1;
        end else if (decide) begin
            armed <= 1'b0;
        end
    end

    // Halves the median and wraps the corrected position into the frame.
    always_comb begin
        ofs_c = halve_tz(int'(med));
        pos   = int'(cur_slot) * K + ofs_c;
        if (pos < 0) begin
            pos = pos + FRAME_TICKS;
        end else if (pos >= FRAME_TICKS) begin
            pos = pos - FRAME_TICKS;
        end
    end

    // Registers the decision results for the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_en     <= 1'b0;
            load_slot   <= '0;
            load_tick   <= '0;
            corr_offset <= '0;
        end else begin
            load_en <= decide && (cnt != '0);
            if (decide) begin
                corr_offset <= (cnt == '0) ? '0 : EW'(ofs_c);
                load_slot   <= SLOT_W'(pos / K);
                load_tick   <= TICK_W'(pos % K);
            end
        end
    end

    AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> ((int'(load_slot) < C) && (int'(load_tick) < K))); // R8
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en); // R6
    AST_EMPTY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && (cnt == '0)) |=> (!load_en && (corr_offset == '0))); // R7

endmodule

// File: rtl/phase_median_corrector.sv
// Top: phase error capture, median selection and once-per-frame correction.
// Assumes the slot timer drives cur_slot/cur_tick and accepts load_en loads.
module phase_median_corrector #(
    parameter int C     = 10,
    parameter int N_ACT = 3,
    parameter int K     = 29,
    parameter int G     = 9,
    parameter int DEPTH = 8,
    localparam int SLOT_W = $clog2(C),
    localparam int TICK_W = $clog2(K),
    localparam int OFS_W  = $clog2(C * K) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    msg_end,
    input  logic [SLOT_W-1:0]       msg_slot,
    input  logic [SLOT_W-1:0]       cur_slot,
    input  logic [TICK_W-1:0]       cur_tick,
    output logic                    load_en,
    output logic [SLOT_W-1:0]       load_slot,
    output logic [TICK_W-1:0]       load_tick,
    output logic signed [OFS_W-1:0] corr_offset
);

    localparam int CW = $clog2(DEPTH + 1);

    logic signed [OFS_W-1:0] errs [DEPTH];
    logic [CW-1:0]           cnt;
    logic signed [OFS_W-1:0] med;
    logic                    decide;

    pmc_err_store #(
        .K(K), .G(G), .DEPTH(DEPTH), .SLOT_W(SLOT_W), .TICK_W(TICK_W),
        .EW(OFS_W), .CW(CW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .msg_end(msg_end),
        .msg_slot(msg_slot), .cur_slot(cur_slot), .cur_tick(cur_tick),
        .clear(decide), .errs(errs), .cnt(cnt)
    );

    pmc_median #(
        .DEPTH(DEPTH), .EW(OFS_W), .CW(CW)
    ) u_median (
        .errs(errs), .cnt(cnt), .med(med)
    );

    pmc_apply #(
        .C(C), .N_ACT(N_ACT), .K(K), .SLOT_W(SLOT_W), .TICK_W(TICK_W),
        .EW(OFS_W), .CW(CW)
    ) u_apply (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cur_slot(cur_slot),
        .cnt(cnt), .med(med), .decide(decide), .load_en(load_en),
        .load_slot(load_slot), .load_tick(load_tick), .corr_offset(corr_offset)
    );

endmodule

// File: tb/tb_phase_median_corrector.sv
module tb_phase_median_corrector;

    localparam int C = 8, NA = 6, K = 13, G = 3, D = 8;
    localparam int SW = 3, TW = 4, OW = 9;
    localparam int SYNC = (C + NA) / 2;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, msg_end = 1'b0;
    logic [SW-1:0] msg_slot = '0, cur_slot = '0;
    logic [TW-1:0] cur_tick = '0;
    logic load_en;
    logic [SW-1:0] load_slot;
    logic [TW-1:0] load_tick;
    logic signed [OW-1:0] corr_offset;

    int checks = 0, failures = 0;
    int ev [16];
    int nev = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phase_median_corrector #(.C(C), .N_ACT(NA), .K(K), .G(G), .DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .msg_end(msg_end),
        .msg_slot(msg_slot), .cur_slot(cur_slot), .cur_tick(cur_tick),
        .load_en(load_en), .load_slot(load_slot), .load_tick(load_tick),
        .corr_offset(corr_offset));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half(int v);
        if (v < 0) return -((-v) >> 1);
        return v >> 1;
    endfunction

    // R2: event cycle shows a decoy position; the tick cycle position is used.
    task automatic send(int snd, int ls, int lt);
        @(negedge clk);
        msg_end = 1'b1; msg_slot = SW'(snd); cur_slot = SW'((ls + 3) % C); cur_tick = TW'((lt + 5) % K);
        @(negedge clk);
        msg_end = 1'b0; tick_en = 1'b1; cur_slot = SW'(ls); cur_tick = TW'(lt);
        if (nev < D) begin  // R3: extras beyond depth are not recorded
            ev[nev] = (snd * K + K - G) - (ls * K + lt);
            nev++;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic frame_begin();
        @(negedge clk);
        tick_en = 1'b1; cur_slot = '0; cur_tick = '0;
        @(negedge clk);
        tick_en = 1'b0;
        nev = 0;
    endtask

    task automatic sync_check(int lt, string tag);
        int s [16];
        int med, ofs, p, t, eload;
        for (int i = 0; i < nev; i++) s[i] = ev[i];
        if (nev >= 3) begin
            for (int i = 0; i < nev; i++)
                for (int j = 0; j + 1 < nev - i; j++)
                    if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
            med = s[(nev - 1) / 2];  // R4 lower middle
        end else begin
            med = ev[0];             // R4 first stored
        end
        eload = (nev > 0);
        ofs = eload ? half(med) : 0; // R5, R7
        p = SYNC * K + ofs;          // R8
        if (p < 0) p += C * K; else if (p >= C * K) p -= C * K;
        @(negedge clk);
        tick_en = 1'b1; cur_slot = SW'(SYNC); cur_tick = TW'(lt);
        @(negedge clk);
        tick_en = 1'b0;
        chk(load_en == eload, {tag, " R6 load_en"}, int'(load_en), eload);
        chk(int'(corr_offset) == ofs, {tag, " R5 offset"}, int'(corr_offset), ofs);
        if (eload) begin
            chk(int'(load_slot) == p / K, {tag, " R8 slot"}, int'(load_slot), p / K);
            chk(int'(load_tick) == p % K, {tag, " R8 tick"}, int'(load_tick), p % K);
        end
        @(negedge clk);
        chk(load_en == 1'b0, {tag, " R6 pulse"}, int'(load_en), 0);
        // R6: another tick in the sync slot makes no second decision
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
        chk(load_en == 1'b0, {tag, " R6 once"}, int'(load_en), 0);
        chk(int'(corr_offset) == ofs, {tag, " R6 hold"}, int'(corr_offset), ofs);
        nev = 0;                     // R9: store empties at the decision
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(load_en == 1'b0, "R1 load_en", int'(load_en), 0);
        chk(corr_offset == '0, "R1 offset", int'(corr_offset), 0);

        // R2, R8: sweep all sender/local slot pairings with one message each
        for (int s = 0; s < NA; s++)
            for (int l = 0; l < NA; l++) begin
                frame_begin();
                send(s, l, (s * 5 + l * 3) % K);
                sync_check((s + l) % K, "sweep");
            end

        // R5: small medians truncate toward zero
        frame_begin(); send(0, 0, 9);  sync_check(0, "gain+1");
        frame_begin(); send(0, 0, 11); sync_check(0, "gain-1");
        frame_begin(); send(0, 1, 0);  sync_check(0, "gain-3");

        // R8: positive wrap past the frame end
        frame_begin(); send(5, 0, 0); sync_check(4, "wrap");

        // R3, R4, R7, R9: counts 0..10 with varied orderings
        for (int n = 0; n <= 10; n++) begin
            frame_begin();
            for (int k = 0; k < n; k++)
                send((k * 5 + 1) % NA, (k * 3 + n) % NA, (k * 7 + n) % K);
            sync_check(n % K, "count");
        end

        // R7: empty frame after a nonzero correction clears the offset
        frame_begin(); send(5, 0, 0); sync_check(0, "pre-empty");
        frame_begin(); sync_check(0, "empty");

        // R9: a single message after a full frame uses only itself
        frame_begin();
        for (int k = 0; k < 9; k++) send(k % NA, 0, k);
        sync_check(0, "full");
        frame_begin(); send(1, 2, 3); sync_check(0, "after-clear");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule